// File: doc/BRIEF.md
# Load/Store Address Generator

This block turns the addressing fields of a memory transfer into the address that goes to memory and the value that goes back into the base register. It handles three indexing styles. In offset mode the base is adjusted and nothing is written back. In pre-update mode the adjusted base is both the address and the new base. In post-update mode the old base is the address and the adjusted base is written back. The offset is either a 12-bit unsigned immediate or a second register value shifted left by a chosen amount. A direction bit picks whether the offset is added or subtracted. When the base register index names the program counter, the program counter value is used as the base.

Each request enters on a valid/ready handshake and leaves one register stage later, also on a valid/ready handshake. `in_ready` is high whenever the output slot is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every result port holds its value and no new request is taken. A condition-pass input decides whether the transfer takes place. A failed condition suppresses both the memory strobe and the writeback, but the request still passes through the stage. A writeback aimed at the program counter is refused and flagged.

Top module: `lsagu_top`

## Requirements
- R1: With `mode` = 0 (offset), `ea` is the base adjusted by the offset, and `wb_en` and `wb_err` are 0.
- R2: With `mode` = 1 (pre-update), `ea` is the adjusted base, and `wb_en` = 1 with `wb_val` equal to `ea`.
- R3: With `mode` = 2 (post-update), `ea` is the unadjusted base, and `wb_en` = 1 with `wb_val` equal to the adjusted base.
- R4: With `up` = 1 the offset is added to the base. With `up` = 0 it is subtracted. Both results wrap modulo 2^32.
- R5: With `off_sel` = 0 the offset is `imm_off` zero-extended. With `off_sel` = 1 it is `reg_off` shifted left by `shamt` (0 to 31), and bits shifted past bit 31 are lost.
- R6: When `base_idx` = 15 the base is `pc_val`; otherwise it is `base_val`.
- R7: When `cond_pass` = 0 the result has `mem_req`, `wb_en` and `wb_err` all 0, and `ea` and `wb_val` are still computed as for a passing transfer.
- R8: A writeback requested with `base_idx` = 15 and `cond_pass` = 1 gives `wb_en` = 0 and `wb_err` = 1, and `mem_req` stays 1.
- R9: `in_ready` = !`out_valid` || `out_ready`. A request accepted at one rising edge is presented after that edge. While `out_valid` is high and `out_ready` is low, every output holds its value.
- R10: `acc_byte` is carried unchanged to `out_byte`, and byte transfers use the same address rules as word transfers.
- R11: `mode` = 3 behaves exactly like `mode` = 0.
- R12: During and right after reset `out_valid`, `mem_req`, `wb_en` and `wb_err` are 0. All four of these outputs are 0 whenever `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted at this edge if valid |
| base_idx | input | 4 | Base register index; 15 selects the program counter |
| base_val | input | 32 | Base register value |
| pc_val | input | 32 | Program counter value |
| imm_off | input | 12 | Unsigned immediate offset |
| reg_off | input | 32 | Offset register value |
| shamt | input | 5 | Left shift applied to the register offset |
| off_sel | input | 1 | 0 immediate, 1 shifted register |
| mode | input | 2 | 0 offset, 1 pre-update, 2 post-update, 3 as 0 |
| up | input | 1 | 1 add offset, 0 subtract |
| cond_pass | input | 1 | Condition satisfied |
| acc_byte | input | 1 | Byte-sized transfer |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| ea | output | 32 | Effective address |
| mem_req | output | 1 | Memory transfer to be made |
| out_byte | output | 1 | Byte-sized transfer |
| wb_en | output | 1 | Write `wb_val` to the base register |
| wb_val | output | 32 | New base value |
| wb_err | output | 1 | Writeback to the program counter refused |

## Verification
The assertions assume that the request fields stay constant for as long as `in_valid` is high and not yet accepted. They also assume `in_valid` is low during reset. The checker compares each result with the inputs it sampled at the accepting edge. The bench changes its inputs only at falling edges and holds each request until the edge that accepts it, so both assumptions are met. It drops `in_valid` before any further edge and holds `out_ready` low for random stretches to exercise the stall path.

// File: rtl/lsagu_pkg.sv
package lsagu_pkg;
  typedef enum logic [1:0] {
    IDX_OFFSET = 2'd0,
    IDX_PRE_WB = 2'd1,
    IDX_POST   = 2'd2,
    IDX_RSVD   = 2'd3
  } idx_mode_e;

  typedef struct packed {
    logic [31:0] ea;
    logic [31:0] wb_val;
    logic        mem_req;
    logic        wb_en;
    logic        wb_err;
    logic        is_byte;
  } agu_res_t;
endpackage

// File: rtl/lsagu_offset.sv
module lsagu_offset #(
  parameter int AW   = 32,
  parameter int IMMW = 12,
  parameter int SHW  = 5
) (
  input  logic [IMMW-1:0] imm_off,
  input  logic [AW-1:0]   reg_off,
  input  logic [SHW-1:0]  shamt,
  input  logic            off_sel,
  output logic [AW-1:0]   offset
);
  localparam int PADW = AW - IMMW;

  logic [AW-1:0] imm_ext;
  logic [AW-1:0] reg_shifted;

  assign imm_ext     = {{PADW{1'b0}}, imm_off};
  assign reg_shifted = reg_off << shamt;

  always_comb begin
    if (off_sel) offset = reg_shifted;
    else         offset = imm_ext;
  end
endmodule

// File: rtl/lsagu_addr.sv
module lsagu_addr
  import lsagu_pkg::*;
#(
  parameter int AW = 32,
  parameter int RIW = 4,
  parameter logic [RIW-1:0] PC_IDX = '1
) (
  input  logic [RIW-1:0] base_idx,
  input  logic [AW-1:0]  base_val,
  input  logic [AW-1:0]  pc_val,
  input  logic [AW-1:0]  offset,
  input  logic [1:0]     mode,
  input  logic           up,
  input  logic           cond_pass,
  input  logic           acc_byte,
  output agu_res_t       res
);
  idx_mode_e     md;
  logic [AW-1:0] base;
  logic [AW-1:0] adjusted;
  logic          is_pc;
  logic          wants_wb;

  assign md       = idx_mode_e'(mode);
  assign is_pc    = (base_idx == PC_IDX);
  assign base     = is_pc ? pc_val : base_val;
  assign adjusted = up ? (base + offset) : (base - offset);

  always_comb begin
    res         = '0;
    res.is_byte = acc_byte;
    res.mem_req = cond_pass;
    unique case (md)
      IDX_PRE_WB: begin
        res.ea     = adjusted;
        res.wb_val = adjusted;
        wants_wb   = 1'b1;
      end
      IDX_POST: begin
        res.ea     = base;
        res.wb_val = adjusted;
        wants_wb   = 1'b1;
      end
      default: begin
        res.ea     = adjusted;
        res.wb_val = base;
        wants_wb   = 1'b0;
      end
    endcase
    res.wb_en  = cond_pass && wants_wb && !is_pc;
    res.wb_err = cond_pass && wants_wb && is_pc;
  end
endmodule

// File: rtl/lsagu_top.sv
module lsagu_top
  import lsagu_pkg::*;
#(
  parameter int AW   = 32,
  parameter int IMMW = 12,
  parameter int SHW  = 5,
  parameter int RIW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [RIW-1:0]  base_idx,
  input  logic [AW-1:0]   base_val,
  input  logic [AW-1:0]   pc_val,
  input  logic [IMMW-1:0] imm_off,
  input  logic [AW-1:0]   reg_off,
  input  logic [SHW-1:0]  shamt,
  input  logic            off_sel,
  input  logic [1:0]      mode,
  input  logic            up,
  input  logic            cond_pass,
  input  logic            acc_byte,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [AW-1:0]   ea,
  output logic            mem_req,
  output logic            out_byte,
  output logic            wb_en,
  output logic [AW-1:0]   wb_val,
  output logic            wb_err
);
  localparam logic [RIW-1:0] PC_IDX = '1;

  logic [AW-1:0] offset;
  agu_res_t      res_d;
  agu_res_t      res_q;
  logic          vld_q;
  logic          take;

  lsagu_offset #(.AW(AW), .IMMW(IMMW), .SHW(SHW)) u_off (
    .imm_off (imm_off),
    .reg_off (reg_off),
    .shamt   (shamt),
    .off_sel (off_sel),
    .offset  (offset)
  );

  lsagu_addr #(.AW(AW), .RIW(RIW), .PC_IDX(PC_IDX)) u_addr (
    .base_idx  (base_idx),
    .base_val  (base_val),
    .pc_val    (pc_val),
    .offset    (offset),
    .mode      (mode),
    .up        (up),
    .cond_pass (cond_pass),
    .acc_byte  (acc_byte),
    .res       (res_d)
  );

  assign in_ready = !vld_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      if (take) begin
        vld_q <= 1'b1;
        res_q <= res_d;
      end else if (out_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign out_valid = vld_q;
  assign ea        = res_q.ea;
  assign wb_val    = res_q.wb_val;
  assign out_byte  = res_q.is_byte;
  assign mem_req   = vld_q && res_q.mem_req;
  assign wb_en     = vld_q && res_q.wb_en;
  assign wb_err    = vld_q && res_q.wb_err;
endmodule

// File: rtl/lsagu_chk.sv
module lsagu_chk #(
  parameter int AW = 32,
  parameter int RIW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [RIW-1:0] base_idx,
  input logic [AW-1:0]  base_val,
  input logic [AW-1:0]  pc_val,
  input logic [1:0]     mode,
  input logic           cond_pass,
  input logic           acc_byte,
  input logic           out_valid,
  input logic           out_ready,
  input logic [AW-1:0]  ea,
  input logic           mem_req,
  input logic           out_byte,
  input logic           wb_en,
  input logic [AW-1:0]  wb_val,
  input logic           wb_err
);
  logic past_ok;
  logic acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assign acc = in_valid && in_ready;

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!mem_req && !wb_en && !wb_err));

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && out_valid && !out_ready) |=>
      (out_valid && $stable(ea) && $stable(wb_val) && $stable(wb_en)
       && $stable(mem_req) && $stable(out_byte)));

  p_ready_rule_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_cond_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && acc && !cond_pass) |=> (out_valid && !mem_req && !wb_en && !wb_err));

  p_pc_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && acc && cond_pass && base_idx == '1 && (mode == 2'd1 || mode == 2'd2))
      |=> (!wb_en && wb_err && mem_req));

  p_offset_nowb_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && acc && mode == 2'd0) |=> (!wb_en && !wb_err));

  p_pre_wb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && acc && cond_pass && base_idx != '1 && mode == 2'd1)
      |=> (wb_en && wb_val == ea));

  p_post_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && acc && mode == 2'd2)
      |=> (ea == $past((base_idx == '1) ? pc_val : base_val)));

  p_byte_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && acc) |=> (out_byte == $past(acc_byte)));
endmodule

bind lsagu_top lsagu_chk #(.AW(AW), .RIW(RIW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .base_idx  (base_idx),
  .base_val  (base_val),
  .pc_val    (pc_val),
  .mode      (mode),
  .cond_pass (cond_pass),
  .acc_byte  (acc_byte),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .ea        (ea),
  .mem_req   (mem_req),
  .out_byte  (out_byte),
  .wb_en     (wb_en),
  .wb_val    (wb_val),
  .wb_err    (wb_err)
);

// File: tb/test_lsagu_top.sv
module test_lsagu_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic [3:0]  base_idx;
  logic [31:0] base_val, pc_val, reg_off;
  logic [11:0] imm_off;
  logic [4:0]  shamt;
  logic        off_sel, up, cond_pass, acc_byte;
  logic [1:0]  mode;
  logic        out_valid, out_ready;
  logic [31:0] ea, wb_val;
  logic        mem_req, out_byte, wb_en, wb_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsagu_top i_lsagu_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .base_idx(base_idx), .base_val(base_val), .pc_val(pc_val),
    .imm_off(imm_off), .reg_off(reg_off), .shamt(shamt), .off_sel(off_sel),
    .mode(mode), .up(up), .cond_pass(cond_pass), .acc_byte(acc_byte),
    .out_valid(out_valid), .out_ready(out_ready), .ea(ea), .mem_req(mem_req),
    .out_byte(out_byte), .wb_en(wb_en), .wb_val(wb_val), .wb_err(wb_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f_base();
    return (base_idx == 4'hF) ? pc_val : base_val;
  endfunction

  function automatic logic [31:0] f_off();
    return off_sel ? (reg_off << shamt) : {20'd0, imm_off};
  endfunction

  function automatic logic [31:0] f_adj();
    return up ? (f_base() + f_off()) : (f_base() - f_off());
  endfunction

  // Issue the current fields, check the result, stall a while, then drain it.
  task automatic run_op(input string tag, input int stall);
    logic [31:0] e_ea, e_wb;
    logic e_req, e_wben, e_err, e_byte, wants;
    wants  = (mode == 2'd1) || (mode == 2'd2);
    e_ea   = (mode == 2'd2) ? f_base() : f_adj();
    e_wb   = wants ? f_adj() : f_base();
    e_req  = cond_pass;
    e_wben = cond_pass && wants && (base_idx != 4'hF);
    e_err  = cond_pass && wants && (base_idx == 4'hF);
    e_byte = acc_byte;
    chk({tag, " R9 ready when empty"}, 32'(in_ready), 32'd1);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R9 out_valid"}, 32'(out_valid), 32'd1);
    chk({tag, " R1/R2/R3/R4/R5/R6 ea"}, ea, e_ea);
    if (e_wben) chk({tag, " R2/R3 wb_val"}, wb_val, e_wb);
    chk({tag, " R7 mem_req"}, 32'(mem_req), 32'(e_req));
    chk({tag, " R7/R8 wb_en"}, 32'(wb_en), 32'(e_wben));
    chk({tag, " R8 wb_err"}, 32'(wb_err), 32'(e_err));
    chk({tag, " R10 out_byte"}, 32'(out_byte), 32'(e_byte));
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk({tag, " R9 stall hold ea"}, ea, e_ea);
      chk({tag, " R9 stall ready low"}, 32'(in_ready), 32'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk({tag, " R12 drained"}, 32'({out_valid, mem_req, wb_en, wb_err}), 32'd0);
  endtask

  task automatic set_fields(input logic [3:0] bi, input logic [31:0] bv,
                            input logic [31:0] pc, input logic [11:0] im,
                            input logic [31:0] ro, input logic [4:0] sh,
                            input logic os, input logic [1:0] md,
                            input logic u, input logic cp, input logic by);
    base_idx = bi; base_val = bv; pc_val = pc; imm_off = im; reg_off = ro;
    shamt = sh; off_sel = os; mode = md; up = u; cond_pass = cp; acc_byte = by;
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    set_fields(4'd1, 32'h0, 32'h0, 12'h0, 32'h0, 5'd0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    chk("R12 reset quiet", 32'({out_valid, mem_req, wb_en, wb_err}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 after reset", 32'({out_valid, mem_req, wb_en, wb_err}), 32'd0);

    set_fields(4'd1, 32'h1000, 32'h8000, 12'd20, 32'h0, 5'd0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0);
    run_op("R1 offset imm", 1);
    set_fields(4'd1, 32'h1000, 32'h8000, 12'd4, 32'h0, 5'd0, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0);
    run_op("R2 pre-update", 0);
    set_fields(4'd2, 32'h1000, 32'h8000, 12'd4, 32'h0, 5'd0, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0);
    run_op("R3 post-update", 2);
    set_fields(4'd3, 32'h2000, 32'h8000, 12'd1, 32'h0, 5'd0, 1'b0, 2'd2, 1'b1, 1'b1, 1'b1);
    run_op("R10 byte post step 1", 0);
    set_fields(4'd1, 32'h10, 32'h8000, 12'hFFF, 32'h0, 5'd0, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0);
    run_op("R4 subtract wrap", 0);
    set_fields(4'd1, 32'hFFFF_FFF0, 32'h0, 12'h20, 32'h0, 5'd0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0);
    run_op("R4 add wrap", 0);
    set_fields(4'd4, 32'h100, 32'h0, 12'h0, 32'h3, 5'd2, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0);
    run_op("R5 scaled reg", 0);
    set_fields(4'd4, 32'h100, 32'h0, 12'h0, 32'hFFFF_FFFF, 5'd31, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0);
    run_op("R5 shift 31", 0);
    set_fields(4'hF, 32'h100, 32'h4000, 12'd24, 32'h0, 5'd0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0);
    run_op("R6 pc base", 0);
    set_fields(4'hF, 32'h100, 32'h4000, 12'd8, 32'h0, 5'd0, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0);
    run_op("R8 pc writeback", 1);
    set_fields(4'd5, 32'h100, 32'h4000, 12'd8, 32'h0, 5'd0, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0);
    run_op("R7 cond fail", 0);
    set_fields(4'd5, 32'h500, 32'h4000, 12'd8, 32'h0, 5'd0, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0);
    run_op("R11 mode 3", 0);

    void'($urandom(32'd20240611));
    for (int n = 0; n < 400; n++) begin
      set_fields(4'($urandom_range(0, 15)), $urandom(), $urandom(),
                 12'($urandom()), $urandom(), 5'($urandom()), 1'($urandom()),
                 2'($urandom()), 1'($urandom()), ($urandom_range(0, 3) != 0),
                 1'($urandom()));
      run_op("rnd", $urandom_range(0, 2));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule